// File: doc/BRIEF.md
# Three-Bus Add Instruction Sequencer

This block is the hardwired control unit for a processor whose datapath has two source buses, A and B, feeding an ALU. The ALU result drives a third bus, C, and a separate incrementer advances the program counter. The sequencer walks through four steps that fetch one instruction and execute a register-to-register add. It drives every gating signal the datapath needs. It also decodes the instruction's register fields into individual per-register read and write enables.

The four steps run as follows. In the fetch step, the PC is placed on bus B and passed unchanged through the ALU into the memory address register. In the same step a memory read starts and the PC is incremented. The sequencer then holds in a wait step until memory reports completion. Next, the memory data is moved over bus B through the ALU pass mode into the instruction register. Finally, two source registers drive buses A and B at the same time, the ALU adds them, and the sum is written to the destination register. That step also signals instruction end and returns the sequencer to the fetch step.

The register file, the ALU, memory and the instruction register itself are outside this block. Their control inputs come from these outputs, and the instruction register contents arrive on the `instr` input.

Top module: `add3bus_seq`

## Requirements
- R1: While `rst_n` is low, the sequencer is held in the fetch step, which is step code 0 on `step`, with the fetch-step outputs of R2.
- R2: In the fetch step, exactly `pc_to_b`, `alu_pass_b`, `mar_load`, `mem_read` and `pc_inc` are high, and all other controls and enables are low. The next step is the wait step, code 1.
- R3: In the wait step, only `wait_mem` is high. While `mem_done` is low, the sequencer stays in the wait step.
- R4: If `mem_done` is high during a wait-step cycle, the next cycle is the load step, code 2.
- R5: In the load step, exactly `mdr_to_b`, `alu_pass_b` and `ir_load` are high. The next step is the execute step, code 3.
- R6: In the execute step, exactly `alu_sel_a`, `alu_add` and `instr_end` are high among the single controls. `rd_a_en` is one-hot at the index in `instr[3*FW-1:2*FW]`, `rd_b_en` is one-hot at the index in `instr[2*FW-1:FW]`, and `wr_en` is one-hot at the index in `instr[FW-1:0]`, where FW = clog2(NREG).
- R7: The cycle after the execute step is the fetch step.
- R8: Outside the execute step, `rd_a_en`, `rd_b_en` and `wr_en` are all zero.
- R9: `mem_done` has no effect in the fetch, load and execute steps. Those steps each last exactly one cycle whatever its value.
- R10: If two or three register fields name the same register, each enable vector still asserts that register's bit independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_done | input | 1 | Memory function complete |
| instr | input | IRW | Instruction register contents |
| step | output | 2 | Current step code (0 fetch, 1 wait, 2 load, 3 execute) |
| pc_to_b | output | 1 | PC drives bus B |
| alu_pass_b | output | 1 | ALU copies bus B to bus C |
| mar_load | output | 1 | Load memory address register from bus C |
| mem_read | output | 1 | Start memory read |
| pc_inc | output | 1 | Increment PC |
| wait_mem | output | 1 | Waiting for memory completion |
| mdr_to_b | output | 1 | Memory data register drives bus B |
| ir_load | output | 1 | Load instruction register from bus C |
| alu_sel_a | output | 1 | ALU first operand taken from bus A |
| alu_add | output | 1 | ALU performs addition |
| instr_end | output | 1 | Instruction complete |
| rd_a_en | output | NREG | Per-register drive enables onto bus A |
| rd_b_en | output | NREG | Per-register drive enables onto bus B |
| wr_en | output | NREG | Per-register load enables from bus C |

## Verification
The hardest case to reach from the ports is the boundary around the memory wait. This covers both a completion that arrives on the very first wait cycle and one that arrives after several stalled cycles. It also covers a completion signal left high through the steps where it must be ignored. The driver runs instructions with zero, one and several stall cycles. One instruction holds `mem_done` high through every step, and the scoreboard expects the exact step-by-step control word for each cycle. Instructions with repeated register fields check that the enable decoding stays independent per field.

// File: rtl/add3bus_seq.sv
module add3bus_seq #(
  parameter int NREG = 8,
  parameter int IRW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_done,
  input  logic [IRW-1:0]  instr,
  output logic [1:0]      step,
  output logic            pc_to_b,
  output logic            alu_pass_b,
  output logic            mar_load,
  output logic            mem_read,
  output logic            pc_inc,
  output logic            wait_mem,
  output logic            mdr_to_b,
  output logic            ir_load,
  output logic            alu_sel_a,
  output logic            alu_add,
  output logic            instr_end,
  output logic [NREG-1:0] rd_a_en,
  output logic [NREG-1:0] rd_b_en,
  output logic [NREG-1:0] wr_en
);
  localparam int FW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [1:0] {S_FETCH = 2'd0, S_WAIT = 2'd1, S_LOAD = 2'd2, S_EXEC = 2'd3} step_t;

  step_t cur, nxt;

  always_comb begin
    unique case (cur)
      S_FETCH: nxt = S_WAIT;
      S_WAIT:  nxt = mem_done ? S_LOAD : S_WAIT;
      S_LOAD:  nxt = S_EXEC;
      default: nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= S_FETCH;
    else        cur <= nxt;
  end

  wire fetch = (cur == S_FETCH);
  wire exec  = (cur == S_EXEC);

  assign step       = cur;
  assign pc_to_b    = fetch;
  assign mar_load   = fetch;
  assign mem_read   = fetch;
  assign pc_inc     = fetch;
  assign wait_mem   = (cur == S_WAIT);
  assign mdr_to_b   = (cur == S_LOAD);
  assign ir_load    = (cur == S_LOAD);
  assign alu_pass_b = fetch || (cur == S_LOAD);
  assign alu_sel_a  = exec;
  assign alu_add    = exec;
  assign instr_end  = exec;

  wire [FW-1:0] fld_d = instr[FW-1:0];
  wire [FW-1:0] fld_b = instr[2*FW-1:FW];
  wire [FW-1:0] fld_a = instr[3*FW-1:2*FW];

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign rd_a_en[i] = exec && (fld_a == FW'(i));
    assign rd_b_en[i] = exec && (fld_b == FW'(i));
    assign wr_en[i]   = exec && (fld_d == FW'(i));
  end

  AST_FETCH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    pc_to_b |=> wait_mem); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mem && !mem_done) |=> wait_mem); // R3
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mem && mem_done) |=> ir_load); // R4
  AST_LOAD_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> instr_end); // R5
  AST_EXEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end |-> ($onehot0(rd_a_en) && $onehot0(rd_b_en) && $onehot0(wr_en))); // R6
  AST_END_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end |=> (pc_to_b && mem_read)); // R7
  AST_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_end |-> ($countones({rd_a_en, rd_b_en, wr_en}) == 0)); // R8
endmodule

// File: tb/tb_add3bus_seq.sv
module tb_add3bus_seq;
  localparam int NREG = 8;
  localparam int IRW  = 16;
  localparam int VW   = 2 + 11 + 3*NREG;

  logic clk = 0, rst_n = 0, mem_done = 0;
  logic [IRW-1:0] instr = '0;
  logic [1:0] step;
  logic pc_to_b, alu_pass_b, mar_load, mem_read, pc_inc, wait_mem;
  logic mdr_to_b, ir_load, alu_sel_a, alu_add, instr_end;
  logic [NREG-1:0] rd_a_en, rd_b_en, wr_en;

  add3bus_seq #(.NREG(NREG), .IRW(IRW)) dut (
    .clk(clk), .rst_n(rst_n), .mem_done(mem_done), .instr(instr), .step(step),
    .pc_to_b(pc_to_b), .alu_pass_b(alu_pass_b), .mar_load(mar_load),
    .mem_read(mem_read), .pc_inc(pc_inc), .wait_mem(wait_mem),
    .mdr_to_b(mdr_to_b), .ir_load(ir_load), .alu_sel_a(alu_sel_a),
    .alu_add(alu_add), .instr_end(instr_end),
    .rd_a_en(rd_a_en), .rd_b_en(rd_b_en), .wr_en(wr_en));

  always #5 clk = ~clk;

  typedef struct { logic [VW-1:0] v; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done_flag = 0;

  function automatic logic [VW-1:0] expv(int s, logic [IRW-1:0] w);
    logic [NREG-1:0] a, b, d;
    logic [10:0] c;
    a = '0; b = '0; d = '0;
    case (s)
      0: c = 11'b11111000000;
      1: c = 11'b00000100000;
      2: c = 11'b01000011000;
      default: begin
        c = 11'b00000000111;
        a[w[8:6]] = 1'b1; b[w[5:3]] = 1'b1; d[w[2:0]] = 1'b1;
      end
    endcase
    return {2'(s), c, a, b, d};
  endfunction

  task automatic item(int s, bit m, string tag);
    item_t it;
    mem_done = m;
    it.v = expv(s, instr); it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic run_instr(int a, int b, int d, int nwait, bit noise, string first_tag);
    instr = IRW'({a[2:0], b[2:0], d[2:0]}) | 16'hA000;
    item(0, noise, first_tag);
    for (int i = 0; i < nwait; i++) item(1, 0, "R3");
    item(1, 1, "R4");
    item(2, noise, noise ? "R5 R9" : "R5 R8");
    item(3, noise, noise ? "R6 R9" : "R6");
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [VW-1:0] act;
        it = q.pop_front();
        act = {step, pc_to_b, alu_pass_b, mar_load, mem_read, pc_inc, wait_mem,
               mdr_to_b, ir_load, alu_sel_a, alu_add, instr_end, rd_a_en, rd_b_en, wr_en};
        checks++;
        if (act !== it.v) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.v);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    mem_done = 1;
    item(0, 1, "R1");
    item(0, 0, "R1");
    rst_n = 1;
    run_instr(4, 5, 6, 0, 0, "R2 R8");
    run_instr(1, 2, 3, 3, 0, "R7 R2");
    run_instr(7, 0, 2, 1, 1, "R7 R9");
    run_instr(3, 3, 3, 2, 0, "R7 R10");
    run_instr(0, 6, 0, 0, 1, "R7 R10");
    item(0, 0, "R7");
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule